// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Write Sequencer

This block is the host side of a single word write to a serial EEPROM that talks over chip select, a serial clock, a data line toward the part and a data line back from it. A request carries an address, a data word and an organisation select. The block sends the whole write frame and then closes the frame so the part starts its self-timed program cycle. It keeps chip select low for a minimum deselect gap, then raises it and watches the returned ready/busy level. Once the part reports ready, it sends a lone start bit and drops chip select, which clears the status indication. It then reports completion.

The serial clock is divided down from the system clock by a parameter. The deselect gap is derived from the system clock frequency and a nanosecond figure. If the part never reports ready within a programmable cycle budget, the write is abandoned and an error flag accompanies the completion pulse. A build-time mode chooses which event starts the program cycle, and with it the timeout window: chip select falling after the last data bit, or the rising serial clock edge that samples the last data bit.

Top module: `ee3w_write_seq`

## Requirements
- R1: While chip select is high, the bits presented on the rising serial clock edges are, in order: a 1 start bit, the opcode bits 0 then 1, the address most significant bit first, and the data most significant bit first.
- R2: With `req_wide` low the frame carries address bits [ADDR_W_BYTE-1:0] (9 by default) and data bits [7:0]. With `req_wide` high it carries address bits [ADDR_W_WORD-1:0] (8 by default) and data bits [15:0].
- R3: The serial clock is low whenever chip select is low. Each high phase of the serial clock lasts SCK_HALF_DIV system cycles. The outgoing data bit never changes while the serial clock is high.
- R4: After the last data bit, chip select stays low for at least TCSL_CYC = ceil(TCSL_NS * CLK_HZ / 1e9) system cycles, and at most two more, before it is raised for the status phase.
- R5: Completion without error happens only after the returned line has shown the ready level (1) while chip select is high in the status phase. A 0 there keeps the block waiting. The returned line is ignored during the frame, during the deselect gap and during the first two cycles of the status phase.
- R6: After ready is seen, exactly one serial clock pulse with the data bit at 1 is sent while chip select is still high. Chip select then falls and stays low for at least TCSL_CYC cycles before `done`.
- R7: If ready is not seen, `done` and `timeout_err` appear together TIMEOUT_CYC+1 cycles after the cycle in which the program-start event becomes visible (one cycle of slack allowed). Chip select is low at that point and no clear pulse has been sent. `timeout_err` is 0 on a successful completion and is cleared when a new request is accepted.
- R8: With LAST_EDGE_START = 0 the program-start event is chip select falling after the last data bit. With LAST_EDGE_START = 1 it is the rising serial clock edge that carries the last data bit.
- R9: `req_ready` is high only when the block is idle, and a request is taken on `req_valid && req_ready`. `busy` is high from the cycle after acceptance until `done`. `done` lasts exactly one cycle, with `busy` already low.
- R10: During and right after reset, chip select, serial clock, outgoing data, `busy`, `done` and `timeout_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | max(ADDR_W_BYTE, ADDR_W_WORD) | Word or byte address |
| req_data | input | 16 | Write data (low byte used in byte organisation) |
| req_wide | input | 1 | Organisation select: 1 = 16-bit words, 0 = bytes |
| ee_cs | output | 1 | Chip select to the EEPROM, active high |
| ee_sck | output | 1 | Serial clock to the EEPROM |
| ee_mosi | output | 1 | Serial data toward the EEPROM |
| ee_miso | input | 1 | Serial data / ready-busy level from the EEPROM |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Completion was due to the ready timeout |

## Verification
The bench builds two instances at a 125 MHz clock with SCK_HALF_DIV = 3, TIMEOUT_CYC = 300 and TCSL_NS = 250. With these values the deselect gap rounds up from 31.25 to 32 cycles, and the odd divider exposes half-period counting errors. The short timeout makes the abandoned-write path reachable in a few hundred cycles. One instance uses each setting of LAST_EDGE_START, so the two program-start events show up as a shift of the timeout instant. The device model returns a junk high level whenever status is not valid, so a block that samples the returned line too early finishes before the part is ready.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP,
    ST_POLL,
    ST_CLR,
    ST_TAIL
  } ee3w_state_t;

  // nanoseconds to clock cycles, rounded up, never below one
  function automatic int ee3w_ns_to_cycles(input int ns, input int hz);
    longint q;
    q = (longint'(ns) * longint'(hz) + 64'sd999_999_999) / 64'sd1_000_000_000;
    return (q < 1) ? 1 : int'(q);
  endfunction

endpackage

// File: rtl/ee3w_tick_gen.sv
module ee3w_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= tick ? '0 : cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ee3w_cycle_timer.sv
module ee3w_cycle_timer #(
  parameter int MAXV = 32,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt != W'(MAXV)) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ee3w_frame_shreg.sv
module ee3w_frame_shreg #(
  parameter int AN = 9,
  parameter int AW = 8,
  parameter int DN = 8,
  parameter int DW = 16,
  localparam int APW  = (AN > AW) ? AN : AW,
  localparam int NLEN = 3 + AN + DN,
  localparam int WLEN = 3 + AW + DW,
  localparam int FLEN = (NLEN > WLEN) ? NLEN : WLEN,
  localparam int LW   = $clog2(FLEN + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           adv,
  input  logic           wide,
  input  logic [APW-1:0] addr,
  input  logic [DW-1:0]  data,
  output logic           next_bit,
  output logic           last
);
  localparam logic [1:0] OPC_WRITE = 2'b01;

  logic [FLEN-1:0] sr;
  logic [LW-1:0]   left;
  logic [FLEN-1:0] narrow_f, wide_f;

  // left-aligned frames: start bit, opcode, address, data
  always_comb begin
    narrow_f = '0;
    wide_f   = '0;
    narrow_f[FLEN-1]      = 1'b1;
    narrow_f[FLEN-2]      = OPC_WRITE[1];
    narrow_f[FLEN-3]      = OPC_WRITE[0];
    wide_f[FLEN-1]        = 1'b1;
    wide_f[FLEN-2]        = OPC_WRITE[1];
    wide_f[FLEN-3]        = OPC_WRITE[0];
    for (int i = 0; i < AN; i++) narrow_f[FLEN-4-i]      = addr[AN-1-i];
    for (int i = 0; i < DN; i++) narrow_f[FLEN-4-AN-i]   = data[DN-1-i];
    for (int i = 0; i < AW; i++) wide_f[FLEN-4-i]        = addr[AW-1-i];
    for (int i = 0; i < DW; i++) wide_f[FLEN-4-AW-i]     = data[DW-1-i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= wide ? wide_f : narrow_f;
      left <= wide ? LW'(WLEN) : LW'(NLEN);
    end else if (adv) begin
      sr   <= sr << 1;
      left <= left - 1'b1;
    end
  end

  assign next_bit = sr[FLEN-2];
  assign last     = (left == LW'(1));

  AST_ADV_WITHIN_FRAME: assert property (@(posedge clk) disable iff (rst)
    adv |-> (left > LW'(1))); // R1

endmodule

// File: rtl/ee3w_write_seq.sv
module ee3w_write_seq
  import ee3w_pkg::*;
#(
  parameter int CLK_HZ          = 125_000_000,
  parameter int TCSL_NS         = 250,
  parameter int SCK_HALF_DIV    = 4,
  parameter int ADDR_W_BYTE     = 9,
  parameter int ADDR_W_WORD     = 8,
  parameter int TIMEOUT_CYC     = 100_000,
  parameter bit LAST_EDGE_START = 1'b0,
  localparam int APW      = (ADDR_W_BYTE > ADDR_W_WORD) ? ADDR_W_BYTE : ADDR_W_WORD,
  localparam int DW       = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [APW-1:0] req_addr,
  input  logic [DW-1:0]  req_data,
  input  logic           req_wide,
  output logic           ee_cs,
  output logic           ee_sck,
  output logic           ee_mosi,
  input  logic           ee_miso,
  output logic           busy,
  output logic           done,
  output logic           timeout_err
);
  localparam int DN       = 8;
  localparam int TCSL_CYC = ee3w_ns_to_cycles(TCSL_NS, CLK_HZ);
  localparam int GW       = $clog2(TCSL_CYC + 1);
  localparam int PW       = $clog2(TIMEOUT_CYC + 1);

  ee3w_state_t st, st_n;
  logic cs_q, sck_q, mosi_q, busy_q, done_q, tout_q;
  logic cs_n, sck_n, mosi_n, busy_n, done_n, tout_n;
  logic ld, adv, trs, gclr, pclr;
  logic tick, sh_next, sh_last;
  logic miso_s1, miso_s2;
  logic [1:0] poll_cnt;
  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] prog_cnt;
  logic poll_ok;

  ee3w_tick_gen #(.DIV(SCK_HALF_DIV)) u_tick (
    .clk(clk), .rst(rst), .en((st == ST_SHIFT) || (st == ST_CLR)),
    .restart(trs), .tick(tick)
  );

  ee3w_frame_shreg #(.AN(ADDR_W_BYTE), .AW(ADDR_W_WORD), .DN(DN), .DW(DW)) u_frame (
    .clk(clk), .rst(rst), .load(ld), .adv(adv), .wide(req_wide),
    .addr(req_addr), .data(req_data), .next_bit(sh_next), .last(sh_last)
  );

  ee3w_cycle_timer #(.MAXV(TCSL_CYC)) u_gap (
    .clk(clk), .rst(rst), .clr(gclr), .cnt(gap_cnt)
  );

  ee3w_cycle_timer #(.MAXV(TIMEOUT_CYC)) u_prog (
    .clk(clk), .rst(rst), .clr(pclr), .cnt(prog_cnt)
  );

  assign poll_ok = (poll_cnt == 2'd2);

  always_comb begin
    st_n   = st;
    cs_n   = cs_q;
    sck_n  = sck_q;
    mosi_n = mosi_q;
    busy_n = busy_q;
    done_n = 1'b0;
    tout_n = tout_q;
    ld     = 1'b0;
    adv    = 1'b0;
    trs    = 1'b0;
    gclr   = 1'b0;
    pclr   = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (req_valid && !busy_q) begin
          st_n   = ST_SHIFT;
          cs_n   = 1'b1;
          sck_n  = 1'b0;
          mosi_n = 1'b1;
          busy_n = 1'b1;
          tout_n = 1'b0;
          ld     = 1'b1;
          trs    = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_n = 1'b1;
            if (LAST_EDGE_START && sh_last) pclr = 1'b1;
          end else begin
            sck_n = 1'b0;
            if (sh_last) begin
              cs_n   = 1'b0;
              mosi_n = 1'b0;
              st_n   = ST_GAP;
              gclr   = 1'b1;
              if (!LAST_EDGE_START) pclr = 1'b1;
            end else begin
              adv    = 1'b1;
              mosi_n = sh_next;
            end
          end
        end
      end
      ST_GAP: begin
        if (gap_cnt == GW'(TCSL_CYC - 1)) begin
          cs_n = 1'b1;
          st_n = ST_POLL;
        end
      end
      ST_POLL: begin
        if (poll_ok && miso_s2) begin
          st_n   = ST_CLR;
          mosi_n = 1'b1;
          trs    = 1'b1;
        end else if (prog_cnt >= PW'(TIMEOUT_CYC - 1)) begin
          cs_n   = 1'b0;
          st_n   = ST_IDLE;
          busy_n = 1'b0;
          done_n = 1'b1;
          tout_n = 1'b1;
        end
      end
      ST_CLR: begin
        if (tick) begin
          if (!sck_q) begin
            sck_n = 1'b1;
          end else begin
            sck_n  = 1'b0;
            cs_n   = 1'b0;
            mosi_n = 1'b0;
            st_n   = ST_TAIL;
            gclr   = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (gap_cnt == GW'(TCSL_CYC - 1)) begin
          st_n   = ST_IDLE;
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cs_q     <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      tout_q   <= 1'b0;
      miso_s1  <= 1'b0;
      miso_s2  <= 1'b0;
      poll_cnt <= '0;
    end else begin
      st      <= st_n;
      cs_q    <= cs_n;
      sck_q   <= sck_n;
      mosi_q  <= mosi_n;
      busy_q  <= busy_n;
      done_q  <= done_n;
      tout_q  <= tout_n;
      miso_s1 <= ee_miso;
      miso_s2 <= miso_s1;
      if (st != ST_POLL)      poll_cnt <= '0;
      else if (!poll_ok)      poll_cnt <= poll_cnt + 1'b1;
    end
  end

  assign req_ready   = ~busy_q;
  assign ee_cs       = cs_q;
  assign ee_sck      = sck_q;
  assign ee_mosi     = mosi_q;
  assign busy        = busy_q;
  assign done        = done_q;
  assign timeout_err = tout_q;

  AST_SCK_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !ee_cs |-> !ee_sck); // R3
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ee_sck && $past(ee_sck)) |-> $stable(ee_mosi)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy))); // R9
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (st == ST_IDLE)); // R9
  AST_TOUT_RISES_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(timeout_err) |-> (done && !ee_cs)); // R7

endmodule

// File: tb/ee3w_write_seq_tb_top.sv
`timescale 1ns/1ps

module ee3w_dev_model #(
  parameter bit ALT         = 1'b0,
  parameter int SCK_DIV     = 3,
  parameter int TCSL_CYC    = 32,
  parameter int TIMEOUT_CYC = 300,
  parameter int BUSY_CYC    = 120,
  parameter int AN          = 9,
  parameter int AW          = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs,
  input  logic        sck,
  input  logic        mosi,
  output logic        miso,
  input  logic        req_valid,
  input  logic        req_ready,
  input  logic [8:0]  req_addr,
  input  logic [15:0] req_data,
  input  logic        req_wide,
  input  logic        busy,
  input  logic        done,
  input  logic        tout,
  input  logic        stuck,
  output int          nchk,
  output int          nfail
);
  bit q[$];
  bit expq[$];
  bit prev_sck, prev_cs, prev_mosi, prev_done;
  bit exp_busy, acc_pend, started, status_win, clr_bit, stuck_cur;
  int phase, hi_run, since_start, dev_left, gap_run, clr_pulses, tail_run;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s (mode %0d): got %0d expected %0d", tag, what, ALT, act, exp);
    end
  endtask

  task automatic start_prog();
    started     = 1'b1;
    since_start = 1;
    dev_left    = stuck_cur ? (1 << 30) : BUSY_CYC;
  endtask

  initial begin
    nchk  = 0;
    nfail = 0;
    miso  = 1'b1;
  end

  always @(negedge clk) begin
    if (rst) begin
      phase = 0; exp_busy = 0; acc_pend = 0; started = 0; status_win = 0;
      hi_run = 0; since_start = 0; dev_left = 0; gap_run = 0; clr_pulses = 0;
      tail_run = 0; clr_bit = 0; stuck_cur = 0;
      q.delete(); expq.delete();
      miso = 1'b1;
    end else begin
      // per-clock busy reference (R9)
      if (acc_pend) begin exp_busy = 1'b1; acc_pend = 1'b0; end
      if (done) exp_busy = 1'b0;
      chk(busy == exp_busy, "R9", "busy vs reference", busy, exp_busy);

      if (req_valid && req_ready) begin
        acc_pend = 1'b1;
        phase = 1;
        q.delete(); expq.delete();
        stuck_cur = stuck;
        clr_pulses = 0; status_win = 0; started = 0;
        expq.push_back(1'b1); expq.push_back(1'b0); expq.push_back(1'b1);
        if (req_wide) begin
          for (int i = AW - 1; i >= 0; i--) expq.push_back(req_addr[i]);
          for (int i = 15; i >= 0; i--)     expq.push_back(req_data[i]);
        end else begin
          for (int i = AN - 1; i >= 0; i--) expq.push_back(req_addr[i]);
          for (int i = 7; i >= 0; i--)      expq.push_back(req_data[i]);
        end
      end

      if (started) begin
        since_start++;
        if (dev_left > 0) dev_left--;
      end

      if (!cs && sck) chk(1'b0, "R3", "sck high with cs low", sck, 0);

      if (sck && !prev_sck) begin
        hi_run = 1;
        if (phase == 1) begin
          q.push_back(mosi);
          if (ALT && q.size() == expq.size()) start_prog();
        end else if (phase == 2 && status_win) begin
          clr_pulses++;
          clr_bit = mosi;
        end
      end else if (sck && prev_sck) begin
        hi_run++;
        if (mosi != prev_mosi) chk(1'b0, "R3", "mosi moved while sck high", mosi, prev_mosi);
      end else if (!sck && prev_sck) begin
        chk(hi_run == SCK_DIV, "R3", "sck high phase length", hi_run, SCK_DIV);
      end

      if (prev_cs && !cs) begin
        if (phase == 1) begin
          longint act, exv;
          bit same;
          act = 0; exv = 0;
          same = (q.size() == expq.size());
          foreach (q[i]) act = (act << 1) | longint'(q[i]);
          foreach (expq[i]) begin
            exv = (exv << 1) | longint'(expq[i]);
            if (i < q.size() && q[i] != expq[i]) same = 1'b0;
          end
          chk(same, "R1 R2", "write frame bits", act, exv);
          chk(q.size() == expq.size(), "R2", "frame length", q.size(), expq.size());
          phase = 2;
          status_win = 0;
          gap_run = 0;
          if (!ALT) start_prog();
        end else if (phase == 2 && status_win) begin
          status_win = 0;
          phase = 3;
          tail_run = 0;
        end
      end

      if (phase == 2 && !status_win) begin
        if (!cs) gap_run++;
        else if (!prev_cs) begin
          chk(gap_run >= TCSL_CYC && gap_run <= TCSL_CYC + 2, "R4",
              "deselect gap cycles", gap_run, TCSL_CYC);
          status_win = 1;
        end
      end

      if (phase == 3 && !cs) tail_run++;

      if (done && prev_done) chk(1'b0, "R9", "done longer than one cycle", 2, 1);
      if (done) begin
        chk(phase == 3, "R9", "done without a finished frame", phase, 3);
        if (stuck_cur) begin
          chk(tout == 1'b1, "R7", "timeout flag", tout, 1);
          chk(since_start >= TIMEOUT_CYC + 1 && since_start <= TIMEOUT_CYC + 2,
              ALT ? "R8" : "R7", "cycles from program start to timeout", since_start,
              TIMEOUT_CYC + 1);
          chk(!cs, "R7", "cs at timeout", cs, 0);
          chk(clr_pulses == 0, "R7", "clear pulses on timeout", clr_pulses, 0);
        end else begin
          chk(tout == 1'b0, "R7", "timeout flag on success", tout, 0);
          chk(dev_left == 0, "R5", "completion before device ready", dev_left, 0);
          chk(clr_pulses == 1 && clr_bit, "R6", "clear start bit pulses", clr_pulses, 1);
          chk(tail_run >= TCSL_CYC, "R6", "cs low after clear", tail_run, TCSL_CYC);
        end
        phase = 0;
        started = 0;
      end

      // returned line: status only in the status window, junk high otherwise
      if (phase == 2 && status_win && cs) miso = (dev_left == 0);
      else                                 miso = 1'b1;
    end
    prev_sck  = sck;
    prev_cs   = cs;
    prev_mosi = mosi;
    prev_done = done;
  end

endmodule

module ee3w_write_seq_tb_top;
  localparam int CLK_HZ   = 125_000_000;
  localparam int DIV      = 3;
  localparam int TOUT     = 300;
  localparam int TCSL_EXP = 32; // ceil(250 ns * 125 MHz) = ceil(31.25)

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic req_wide = 1'b0;
  logic stuck = 1'b0;

  logic rdy_a, cs_a, sck_a, mosi_a, miso_a, busy_a, done_a, tout_a;
  logic rdy_b, cs_b, sck_b, mosi_b, miso_b, busy_b, done_b, tout_b;
  int nchk_a, nfail_a, nchk_b, nfail_b;
  int tchk = 0, tfail = 0;
  bit got_a, got_b, finished;

  always #4 clk = ~clk;

  ee3w_write_seq #(.CLK_HZ(CLK_HZ), .TCSL_NS(250), .SCK_HALF_DIV(DIV),
                   .TIMEOUT_CYC(TOUT), .LAST_EDGE_START(1'b0)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_a),
    .req_addr(req_addr), .req_data(req_data), .req_wide(req_wide),
    .ee_cs(cs_a), .ee_sck(sck_a), .ee_mosi(mosi_a), .ee_miso(miso_a),
    .busy(busy_a), .done(done_a), .timeout_err(tout_a)
  );

  ee3w_write_seq #(.CLK_HZ(CLK_HZ), .TCSL_NS(250), .SCK_HALF_DIV(DIV),
                   .TIMEOUT_CYC(TOUT), .LAST_EDGE_START(1'b1)) dut_alt_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rdy_b),
    .req_addr(req_addr), .req_data(req_data), .req_wide(req_wide),
    .ee_cs(cs_b), .ee_sck(sck_b), .ee_mosi(mosi_b), .ee_miso(miso_b),
    .busy(busy_b), .done(done_b), .timeout_err(tout_b)
  );

  ee3w_dev_model #(.ALT(1'b0), .SCK_DIV(DIV), .TCSL_CYC(TCSL_EXP), .TIMEOUT_CYC(TOUT)) mdl_i (
    .clk(clk), .rst(rst), .cs(cs_a), .sck(sck_a), .mosi(mosi_a), .miso(miso_a),
    .req_valid(req_valid), .req_ready(rdy_a), .req_addr(req_addr), .req_data(req_data),
    .req_wide(req_wide), .busy(busy_a), .done(done_a), .tout(tout_a), .stuck(stuck),
    .nchk(nchk_a), .nfail(nfail_a)
  );

  ee3w_dev_model #(.ALT(1'b1), .SCK_DIV(DIV), .TCSL_CYC(TCSL_EXP), .TIMEOUT_CYC(TOUT)) mdl_alt_i (
    .clk(clk), .rst(rst), .cs(cs_b), .sck(sck_b), .mosi(mosi_b), .miso(miso_b),
    .req_valid(req_valid), .req_ready(rdy_b), .req_addr(req_addr), .req_data(req_data),
    .req_wide(req_wide), .busy(busy_b), .done(done_b), .tout(tout_b), .stuck(stuck),
    .nchk(nchk_b), .nfail(nfail_b)
  );

  always @(negedge clk) begin
    if (done_a) got_a = 1'b1;
    if (done_b) got_b = 1'b1;
  end

  task automatic tchk_one(input bit ok, input string tag, input string what,
                          input int act, input int exp);
    tchk++;
    if (!ok) begin
      tfail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed",
               tchk + nchk_a + nchk_b, tfail + nfail_a + nfail_b);
    end
    $finish;
  endtask

  task automatic do_write(input logic [8:0] a, input logic [15:0] d, input bit w,
                          input bit stk);
    @(posedge clk); #1;
    got_a = 1'b0; got_b = 1'b0;
    req_addr = a; req_data = d; req_wide = w; stuck = stk;
    req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    tchk_one(busy_a && busy_b, "R9", "busy after accept", busy_a + 2 * busy_b, 3);
    tchk_one(!rdy_a && !rdy_b, "R9", "req_ready while busy", rdy_a + 2 * rdy_b, 0);
    tchk_one(!tout_a && !tout_b, "R7", "timeout flag cleared on accept",
             tout_a + 2 * tout_b, 0);
    while (!(got_a && got_b)) @(posedge clk);
    @(negedge clk);
    tchk_one(rdy_a && rdy_b, "R9", "req_ready after done", rdy_a + 2 * rdy_b, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tfail++;
    $display("FAIL watchdog: run did not finish, got %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    tchk_one({cs_a, sck_a, mosi_a, busy_a, done_a, tout_a} == 6'b0, "R10",
             "outputs in reset (default mode)", {cs_a, sck_a, mosi_a, busy_a, done_a, tout_a}, 0);
    tchk_one({cs_b, sck_b, mosi_b, busy_b, done_b, tout_b} == 6'b0, "R10",
             "outputs in reset (last-edge mode)", {cs_b, sck_b, mosi_b, busy_b, done_b, tout_b}, 0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    tchk_one(rdy_a && rdy_b && !cs_a && !cs_b, "R10", "idle after reset",
             rdy_a + 2 * rdy_b, 3);

    do_write(9'h1A5, 16'h003C, 1'b0, 1'b0);  // byte org, R1 R2
    do_write(9'h0C3, 16'hA55A, 1'b1, 1'b0);  // word org, R2
    do_write(9'h100, 16'h0081, 1'b0, 1'b0);  // only the top address bit set
    do_write(9'h000, 16'hFFFF, 1'b1, 1'b0);  // all-ones data word
    do_write(9'h155, 16'h00AA, 1'b0, 1'b1);  // part never ready: R7 R8
    do_write(9'h05A, 16'h0001, 1'b1, 1'b0);  // recovery after timeout, R7
    repeat (4) @(posedge clk);
    summary();
  end

endmodule